// File: doc/BRIEF.md
# Debug NMI Source Gate

This block collects the three events that may raise the top-priority (level 7) interrupt used by an on-chip debug monitor. Two of them come from inside the debug logic: a program-breakpoint hit and a bus-breakpoint hit. The third is an active-low external debug request pin. Each event is captured in its own status bit. Software reads these bits to learn which source fired, and clears a bit by writing 1 to it.

The block drives one level-7 request line. It also gives the interrupt acknowledge logic a vector. Normally that vector is a fixed monitor entry address. When the hard-vector-disable input is high, the block instead raises a flag that tells the system interrupt controller to supply the vector.

When the module enable is low, the two internal sources are ignored and only the external pin can raise the request. All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `dbg_nmi_gate`

## Requirements
- R1: After reset, `status` is 3'b000 and `nmi_req` is 0.
- R2: When `prog_hit` is high at a rising clock edge and `mod_en` is high, status bit 0 (program breakpoint) is 1 after that edge.
- R3: When `bus_hit` is high at a rising clock edge and `mod_en` is high, status bit 1 (bus breakpoint) is 1 after that edge.
- R4: A high-to-low transition of `ext_req_n` sets status bit 2 (external). The bit becomes visible after the third rising edge that samples the pin low. A pin that stays low, or a rising transition, sets nothing.
- R5: `nmi_req` is high exactly while any of these holds: (status bit 0 AND `prog_en` AND `mod_en`), (status bit 1 AND `bus_en` AND `mod_en`), or status bit 2.
- R6: A cycle with `wr_en` high clears every status bit whose `wr_data` bit is 1. Status bits whose `wr_data` bit is 0 keep their value.
- R7: An event that sets a status bit on the same edge as a clear write to that bit wins, and the bit stays 1.
- R8: While `mod_en` is low, `prog_hit` and `bus_hit` set no status bit and internal status bits do not drive `nmi_req`. The external source keeps working.
- R9: While `hvec_dis` is 0, `vec_addr` is 32'hFFFC0010 and `vec_ext` is 0. While `hvec_dis` is 1, `vec_ext` is 1 and `vec_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en | input | 1 | Debug module enable |
| prog_en | input | 1 | Lets the program-breakpoint bit raise the request |
| bus_en | input | 1 | Lets the bus-breakpoint bit raise the request |
| hvec_dis | input | 1 | Hands vector generation to the system interrupt controller |
| prog_hit | input | 1 | Program-breakpoint hit pulse |
| bus_hit | input | 1 | Bus-breakpoint hit pulse |
| ext_req_n | input | 1 | Asynchronous external debug request, falling-edge active |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 3 | Write-1-to-clear mask (bit0 program, bit1 bus, bit2 external) |
| status | output | 3 | Latched source bits (same bit order as wr_data) |
| nmi_req | output | 1 | Level-7 interrupt request |
| vec_addr | output | 32 | Fixed monitor vector address, or 0 |
| vec_ext | output | 1 | Vector to be supplied by the system interrupt controller |

## Verification
The assertions check the following on every cycle:
- the request line agrees with the enabled status bits, including the disabled-module fallback to the external source;
- a set event wins over a clear write on the same edge;
- a bit that is neither written nor hit keeps its value;
- the vector outputs follow `hvec_dis`.

Only the bench scenarios can show the latency of the external pin through its synchroniser, measured edge by edge. The same holds for rejection of a pin that stays low or rises, and for agreement with a reference model under long random mixes of hits, writes and enable changes.

// File: rtl/dbg_nmi_pkg.sv
package dbg_nmi_pkg;
  localparam int NSRC     = 3;
  localparam int SRC_PROG = 0;
  localparam int SRC_BUS  = 1;
  localparam int SRC_EXT  = 2;
  localparam logic [31:0] DEF_VEC = 32'hFFFC0010;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/dbg_pin_fall.sv
module dbg_pin_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= pin_n;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b1;
    else last <= chain[STAGES-1];
  end

  assign fall = last & ~chain[STAGES-1];
endmodule

// File: rtl/dbg_status_bank.sv
module dbg_status_bank
  import dbg_nmi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_i,
  input  src_vec_t clr_i,
  output src_vec_t st_o
);
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_o[g] <= 1'b0;
        else if (set_i[g]) st_o[g] <= 1'b1;
        else if (clr_i[g]) st_o[g] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/dbg_vec_sel.sv
module dbg_vec_sel #(
  parameter int          AW      = 32,
  parameter logic [AW-1:0] VEC_ADDR = '0
) (
  input  logic          hvec_dis,
  output logic [AW-1:0] vec_addr,
  output logic          vec_ext
);
  always_comb begin
    vec_ext  = hvec_dis;
    vec_addr = hvec_dis ? '0 : VEC_ADDR;
  end
endmodule

// File: rtl/dbg_nmi_gate.sv
module dbg_nmi_gate
  import dbg_nmi_pkg::*;
#(
  parameter logic [31:0] VEC_ADDR = DEF_VEC,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mod_en,
  input  logic        prog_en,
  input  logic        bus_en,
  input  logic        hvec_dis,
  input  logic        prog_hit,
  input  logic        bus_hit,
  input  logic        ext_req_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_data,
  output logic [2:0]  status,
  output logic        nmi_req,
  output logic [31:0] vec_addr,
  output logic        vec_ext
);
  logic     ext_fall;
  src_vec_t set_v, clr_v, mask_v, st_v;

  dbg_pin_fall #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_req_n), .fall(ext_fall)
  );

  always_comb begin
    set_v           = '0;
    set_v[SRC_PROG] = prog_hit & mod_en;
    set_v[SRC_BUS]  = bus_hit & mod_en;
    set_v[SRC_EXT]  = ext_fall;
    clr_v           = wr_en ? src_vec_t'(wr_data) : '0;
    mask_v           = '0;
    mask_v[SRC_PROG] = prog_en & mod_en;
    mask_v[SRC_BUS]  = bus_en & mod_en;
    mask_v[SRC_EXT]  = 1'b1;
  end

  dbg_status_bank u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .st_o(st_v)
  );

  assign status  = st_v;
  assign nmi_req = |(st_v & mask_v);

  dbg_vec_sel #(.AW(32), .VEC_ADDR(VEC_ADDR)) u_vec (
    .hvec_dis(hvec_dis), .vec_addr(vec_addr), .vec_ext(vec_ext)
  );
endmodule

// File: rtl/dbg_nmi_gate_chk.sv
module dbg_nmi_gate_chk #(
  parameter logic [31:0] VEC_ADDR = 32'hFFFC0010
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mod_en,
  input logic        prog_en,
  input logic        bus_en,
  input logic        hvec_dis,
  input logic        prog_hit,
  input logic        bus_hit,
  input logic        ext_req_n,
  input logic        wr_en,
  input logic [2:0]  wr_data,
  input logic [2:0]  status,
  input logic        nmi_req,
  input logic [31:0] vec_addr,
  input logic        vec_ext
);
  p_prog_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_hit && mod_en) |=> status[0]);
  p_bus_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hit && mod_en) |=> status[1]);
  p_req_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req == ((status[0] && prog_en && mod_en) || (status[1] && bus_en && mod_en) || status[2]));
  p_clear_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && !(prog_hit && mod_en)) |=> !status[0]);
  p_keep_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !(wr_en && wr_data[1])) |=> status[1]);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1] && bus_hit && mod_en) |=> status[1]);
  p_off_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en && !status[0] && !(wr_en && !wr_data[0] && 1'b0)) |=> (status[0] == 1'b0) || $past(mod_en));
  p_off_pin_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> (nmi_req == status[2]));
  p_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hvec_dis ? (vec_ext && vec_addr == 32'h0) : (!vec_ext && vec_addr == VEC_ADDR));
endmodule

bind dbg_nmi_gate dbg_nmi_gate_chk #(.VEC_ADDR(VEC_ADDR)) u_chk (.*);

// File: tb/tb_dbg_nmi_gate.sv
module tb_dbg_nmi_gate;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mod_en = 0, prog_en = 0, bus_en = 0, hvec_dis = 0;
  logic prog_hit = 0, bus_hit = 0, ext_req_n = 1, wr_en = 0;
  logic [2:0] wr_data = 0;
  logic [2:0] status;
  logic nmi_req, vec_ext;
  logic [31:0] vec_addr;

  int checks = 0, errors = 0;
  logic [2:0] exp_st = 3'b000;
  logic h1 = 1, h2 = 1, h3 = 1;

  dbg_nmi_gate dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_req(logic [2:0] s, logic me, logic pe, logic be);
    return (s[0] & pe & me) | (s[1] & be & me) | s[2];
  endfunction

  function automatic logic [2:0] next_st(logic [2:0] s, logic me, logic ph, logic bh,
                                         logic ef, logic we, logic [2:0] wd);
    logic [2:0] c;
    c = we ? wd : 3'b000;
    return (s & ~c) | {ef, bh & me, ph & me};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_model(string tag);
    chk({tag, " status"}, {29'd0, status}, {29'd0, exp_st});
    chk({tag, " nmi_req"}, {31'd0, nmi_req}, {31'd0, exp_req(exp_st, mod_en, prog_en, bus_en)});
    chk({tag, " vec_ext"}, {31'd0, vec_ext}, {31'd0, hvec_dis});
    chk({tag, " vec_addr"}, vec_addr, hvec_dis ? 32'h0 : 32'hFFFC0010);
  endtask

  task automatic cyc();
    logic [2:0] n;
    n = next_st(exp_st, mod_en, prog_hit, bus_hit, (!h2) && h3, wr_en, wr_data);
    @(posedge clk);
    exp_st = n;
    h3 = h2; h2 = h1; h1 = ext_req_n;
    @(negedge clk);
  endtask

  task automatic idle();
    prog_hit = 0; bus_hit = 0; wr_en = 0; wr_data = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status in reset", {29'd0, status}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", {29'd0, status}, 32'd0);
    chk("R1 nmi_req", {31'd0, nmi_req}, 32'd0);

    mod_en = 1; prog_en = 1; bus_en = 1;
    prog_hit = 1; cyc(); idle();
    chk("R2 prog bit", {29'd0, status}, 32'd1);
    chk("R5 req on prog", {31'd0, nmi_req}, 32'd1);
    prog_en = 0; #1;
    chk("R5 prog masked", {31'd0, nmi_req}, 32'd0);
    bus_hit = 1; cyc(); idle();
    chk("R3 bus bit", {29'd0, status}, 32'd3);
    chk("R5 req on bus", {31'd0, nmi_req}, 32'd1);

    wr_en = 1; wr_data = 3'b001; cyc(); idle();
    chk("R6 clear prog keep bus", {29'd0, status}, 32'd2);
    wr_en = 1; wr_data = 3'b000; cyc(); idle();
    chk("R6 zero write no effect", {29'd0, status}, 32'd2);
    wr_en = 1; wr_data = 3'b010; bus_hit = 1; cyc(); idle();
    chk("R7 set beats clear", {29'd0, status}, 32'd2);
    wr_en = 1; wr_data = 3'b111; cyc(); idle();
    chk("R6 clear all", {29'd0, status}, 32'd0);

    ext_req_n = 0;
    cyc(); cyc();
    chk("R4 not yet after two edges", {29'd0, status}, 32'd0);
    cyc();
    chk("R4 set after third edge", {29'd0, status}, 32'd4);
    chk("R5 req on ext", {31'd0, nmi_req}, 32'd1);
    wr_en = 1; wr_data = 3'b100; cyc(); idle();
    repeat (4) cyc();
    chk("R4 level low no re-set", {29'd0, status}, 32'd0);
    ext_req_n = 1; repeat (5) cyc();
    chk("R4 rising no set", {29'd0, status}, 32'd0);

    mod_en = 0; prog_hit = 1; bus_hit = 1; cyc(); idle();
    chk("R8 hits ignored", {29'd0, status}, 32'd0);
    ext_req_n = 0; repeat (3) cyc();
    chk("R8 ext still works", {29'd0, status}, 32'd4);
    ext_req_n = 1;
    mod_en = 1; prog_en = 1; prog_hit = 1; cyc(); idle();
    mod_en = 0; #1;
    chk("R8 internal bit masked", {31'd0, nmi_req}, 32'd1);
    wr_en = 1; wr_data = 3'b100; cyc(); idle();
    chk("R8 only internal left", {31'd0, nmi_req}, 32'd0);

    hvec_dis = 0; #1;
    chk("R9 fixed vector", vec_addr, 32'hFFFC0010);
    chk("R9 no ext flag", {31'd0, vec_ext}, 32'd0);
    hvec_dis = 1; #1;
    chk("R9 ext flag", {31'd0, vec_ext}, 32'd1);
    chk("R9 vector zero", vec_addr, 32'd0);

    void'($urandom(32'h5EED));
    for (int i = 0; i < 3000; i++) begin
      chk_model("R5 R6 random");
      mod_en   = ($urandom % 4) != 0;
      prog_en  = $urandom;
      bus_en   = $urandom;
      hvec_dis = $urandom;
      prog_hit = ($urandom % 5) == 0;
      bus_hit  = ($urandom % 5) == 0;
      wr_en    = ($urandom % 3) == 0;
      wr_data  = $urandom;
      if (($urandom % 6) == 0) ext_req_n = ~ext_req_n;
      #1;
      chk_model("R5 R9 random comb");
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule